// File: doc/BRIEF.md
# Receive Frame Host Read Port

This block hands one buffered received frame at a time to a host over a 16-bit read interface. The host sees a byte stream: a 16-bit status word, then a 16-bit length word, then the frame bytes, packed little-endian into words. The host can pull the stream through a single data port that it reads again and again. It can also read a memory window that starts at a fixed offset from the block's address base. Both paths share one read pointer, so they can be mixed freely.

Near the start of the frame, aligned word reads in the window may jump to any address. Byte reads, misaligned reads and reads past the random-access limit are served from the pointer. The frame is released when its last byte is read, when the host issues a skip, or when the host reads the clear-on-read event register, which returns the status word. On release the block asks the upstream queue for the next frame and rewinds to the status word. The frame store itself lives outside the block and is read through a word-address port.

Top module: `rx_frame_read_port`

## Requirements
- R1: While no frame is queued, `empty` is 1, every read returns 0x0000 and `hd_pop` stays 0; after reset `rd_data` is 0x0000.
- R2: Word reads of the data port (`rd_src`=0) return, in turn, the status word, the length word, then frame words with frame byte 2k in bits 7:0 and byte 2k+1 in bits 15:8.
- R3: With `keep_fcs`=1 the length word equals `hd_len` (which counts the 4 FCS bytes). With `keep_fcs`=0 it equals `hd_len`-4, and the stream ends 4 bytes earlier.
- R4: Window reads (`rd_src`=1) at byte addresses at or above WIN_BASE (0x400) that are not random advance the same stream and pointer as the data port.
- R5: A word window read at an even window offset below 122 (status, length and the first 118 frame bytes) and inside the stream returns the word at that offset, and moves the pointer to offset+2.
- R6: A window read at an odd offset, at offset 122 or above, or with `rd_byte`=1 ignores its address and is served from the pointer.
- R7: A byte read returns the byte at the pointer in bits 7:0 with bits 15:8 zero, and advances the pointer by one. A word read at an odd pointer returns the aligned word holding it and moves the pointer to the next even position.
- R8: The read that moves the pointer to or past the stream end pulses `hd_pop` in its cycle. The next read returns the next frame's status word.
- R9: `skip`=1 while a frame is present pulses `hd_pop` in that cycle and releases the frame.
- R10: An event-register read (`rd_src`=2) returns the status word and releases the frame. With no frame queued it returns 0 and does not pop.
- R11: A window read below WIN_BASE returns 0 and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| keep_fcs | input | 1 | 1: FCS bytes are part of the stream and the length |
| rd_en | input | 1 | Read strobe, one read per cycle |
| rd_src | input | 2 | 0 data port, 1 memory window, 2 event register |
| rd_addr | input | ADDR_W | Byte address for window reads |
| rd_byte | input | 1 | 1: byte read, 0: word read |
| skip | input | 1 | Discard the current frame |
| rd_data | output | 16 | Read result, valid the cycle after `rd_en` |
| empty | output | 1 | No frame presented |
| hd_valid | input | 1 | Queue head frame present |
| hd_status | input | 16 | Queue head status word |
| hd_len | input | LEN_W | Queue head byte count including FCS |
| hd_pop | output | 1 | Release of the head frame |
| buf_addr | output | LEN_W | Frame store word index |
| buf_rdata | input | 16 | Frame store word at `buf_addr` |

## Verification
One frame is read completely through the data port in word reads and another completely in window byte reads. Together these separate the word packing, the byte lanes, the length adjustment with FCS dropped and the exact release cycle at even and odd stream lengths. A third frame is swept with random word reads at every even offset up to the limit in descending order. This is followed by odd-offset, over-limit, byte, misaligned-pointer and below-window reads, which tell the random path apart from the sequential one and from ignored reads. The last frames exercise the skip and event-register releases, followed by reads of the drained queue.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
   typedef enum logic [1:0] {
      SRC_PORT = 2'd0,
      SRC_WIN  = 2'd1,
      SRC_EVT  = 2'd2,
      SRC_NONE = 2'd3
   } rxp_src_e;

   localparam int STAT_BYTES = 2;
   localparam int LEN_BYTES  = 2;
   localparam int HDR_BYTES  = STAT_BYTES + LEN_BYTES;
   localparam int FCS_BYTES  = 4;
endpackage

// File: rtl/rxp_access_decode.sv
module rxp_access_decode
   import rxp_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int PW         = 12,
   parameter int WIN_BASE   = 'h400,
   parameter int RAND_LIMIT = 118
) (
   input  logic              rd_en,
   input  logic [1:0]        rd_src,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_byte,
   input  logic [PW-1:0]     ptr,
   input  logic [PW-1:0]     stream_len,
   output logic              stream_rd,
   output logic              evt_rd,
   output logic [PW-1:0]     pos,
   output logic [PW-1:0]     next_ptr
);
   localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(WIN_BASE);
   localparam logic [ADDR_W-1:0] RAND_END = ADDR_W'(HDR_BYTES + RAND_LIMIT);

   logic [ADDR_W-1:0] win_off;
   logic              in_win, is_win, is_port, rand_ok;

   always_comb begin
      win_off  = rd_addr - BASE_A;
      in_win   = (rd_addr >= BASE_A);
      is_win   = (rxp_src_e'(rd_src) == SRC_WIN);
      is_port  = (rxp_src_e'(rd_src) == SRC_PORT);
      rand_ok  = is_win && in_win && !rd_byte && !win_off[0]
                 && (win_off < RAND_END)
                 && (win_off < ADDR_W'(stream_len));
      stream_rd = rd_en && (is_port || (is_win && in_win));
      evt_rd    = rd_en && (rxp_src_e'(rd_src) == SRC_EVT);
      pos       = rand_ok ? PW'(win_off) : ptr;
      if (rd_byte)
         next_ptr = pos + PW'(1);
      else
         next_ptr = {pos[PW-1:1], 1'b0} + PW'(2);
   end
endmodule

// File: rtl/rxp_stream_ctrl.sv
module rxp_stream_ctrl #(
   parameter int PW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hd_valid,
   input  logic          stream_rd,
   input  logic          evt_rd,
   input  logic          skip,
   input  logic [PW-1:0] next_ptr,
   input  logic [PW-1:0] stream_len,
   output logic [PW-1:0] ptr,
   output logic          hd_pop
);
   logic end_hit;

   always_comb begin
      end_hit = stream_rd && hd_valid && (next_ptr >= stream_len);
      hd_pop  = hd_valid && (skip || evt_rd || end_hit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (hd_pop)
         ptr <= '0;
      else if (stream_rd && hd_valid)
         ptr <= next_ptr;
   end

   a_r1_pop_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
      hd_pop |-> hd_valid);
   a_r9_skip_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (skip && hd_valid) |-> hd_pop);
   a_r10_event_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_rd && hd_valid) |-> hd_pop);
   a_r8_restart_at_status: assert property (@(posedge clk) disable iff (!rst_n)
      hd_pop |=> (ptr == '0));
   a_r8_ptr_inside_stream: assert property (@(posedge clk) disable iff (!rst_n)
      hd_valid |-> (ptr < stream_len));
   a_r11_idle_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (!stream_rd && !hd_pop) |=> $stable(ptr));
endmodule

// File: rtl/rxp_data_mux.sv
module rxp_data_mux #(
   parameter int LEN_W   = 11,
   parameter int PW      = 12,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic             rd_byte,
   input  logic             stream_rd,
   input  logic             evt_rd,
   input  logic             hd_valid,
   input  logic [15:0]      hd_status,
   input  logic [LEN_W-1:0] rep_len,
   input  logic [PW-1:0]    pos,
   input  logic [15:0]      buf_rdata,
   output logic [LEN_W-1:0] buf_addr,
   output logic [15:0]      rd_data
);
   logic [PW-2:0] widx, fidx;
   logic [15:0]   word, sel, val;

   always_comb begin
      widx     = pos[PW-1:1];
      fidx     = widx - (PW-1)'(2);
      buf_addr = fidx[LEN_W-1:0];
      if (widx == '0)
         word = hd_status;
      else if (widx == (PW-1)'(1))
         word = 16'(rep_len);
      else
         word = buf_rdata;
      if (rd_byte)
         sel = {8'h00, pos[0] ? word[15:8] : word[7:0]};
      else
         sel = word;
      if (!hd_valid)
         val = '0;
      else if (evt_rd)
         val = hd_status;
      else if (stream_rd)
         val = sel;
      else
         val = '0;
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rd_data <= '0;
            else if (rd_en)
               rd_data <= val;
         end
         a_r1_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && !hd_valid) |=> (rd_data == '0));
      end else begin : g_comb
         assign rd_data = val;
      end
   endgenerate
endmodule

// File: rtl/rx_frame_read_port.sv
module rx_frame_read_port
   import rxp_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int LEN_W      = 11,
   parameter int WIN_BASE   = 'h400,
   parameter int RAND_LIMIT = 118,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              keep_fcs,
   input  logic              rd_en,
   input  logic [1:0]        rd_src,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_byte,
   input  logic              skip,
   output logic [15:0]       rd_data,
   output logic              empty,
   input  logic              hd_valid,
   input  logic [15:0]       hd_status,
   input  logic [LEN_W-1:0]  hd_len,
   output logic              hd_pop,
   output logic [LEN_W-1:0]  buf_addr,
   input  logic [15:0]       buf_rdata
);
   localparam int PW = LEN_W + 1;

   generate
      if (RAND_LIMIT % 2 != 0) begin : g_bad_limit
         $error("RAND_LIMIT must be even");
      end
      if (WIN_BASE % 2 != 0) begin : g_bad_base
         $error("WIN_BASE must be word aligned");
      end
      if (ADDR_W < PW) begin : g_bad_addr
         $error("ADDR_W must cover the stream pointer");
      end
      if (LEN_W < 4 || LEN_W > 16) begin : g_bad_len
         $error("LEN_W out of range");
      end
   endgenerate

   logic [LEN_W-1:0] rep_len;
   logic [PW-1:0]    stream_len, ptr, pos, next_ptr;
   logic             stream_rd, evt_rd;

   always_comb begin
      rep_len    = keep_fcs ? hd_len : hd_len - LEN_W'(FCS_BYTES);
      stream_len = PW'(rep_len) + PW'(HDR_BYTES);
      empty      = !hd_valid;
   end

   rxp_access_decode #(
      .ADDR_W(ADDR_W), .PW(PW), .WIN_BASE(WIN_BASE), .RAND_LIMIT(RAND_LIMIT)
   ) u_dec (
      .rd_en(rd_en), .rd_src(rd_src), .rd_addr(rd_addr), .rd_byte(rd_byte),
      .ptr(ptr), .stream_len(stream_len), .stream_rd(stream_rd),
      .evt_rd(evt_rd), .pos(pos), .next_ptr(next_ptr)
   );

   rxp_stream_ctrl #(.PW(PW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .hd_valid(hd_valid), .stream_rd(stream_rd),
      .evt_rd(evt_rd), .skip(skip), .next_ptr(next_ptr),
      .stream_len(stream_len), .ptr(ptr), .hd_pop(hd_pop)
   );

   rxp_data_mux #(.LEN_W(LEN_W), .PW(PW), .OUT_REG(OUT_REG)) u_mux (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_byte(rd_byte),
      .stream_rd(stream_rd), .evt_rd(evt_rd), .hd_valid(hd_valid),
      .hd_status(hd_status), .rep_len(rep_len), .pos(pos),
      .buf_rdata(buf_rdata), .buf_addr(buf_addr), .rd_data(rd_data)
   );

   a_r7_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
      (stream_rd && hd_valid && rd_byte && !hd_pop) |=> (ptr == $past(pos) + PW'(1)));
   a_r5_pos_even_on_word_window: assert property (@(posedge clk) disable iff (!rst_n)
      (stream_rd && hd_valid && !rd_byte && !hd_pop) |=> (ptr[0] == 1'b0));
endmodule

// File: tb/rx_frame_read_port_bench.sv
module rx_frame_read_port_bench;
   localparam int NF = 5;
   localparam logic [1:0] S_PORT = 2'd0, S_WIN = 2'd1, S_EVT = 2'd2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0, rd_byte = 1'b0, skip = 1'b0;
   logic [1:0]  rd_src = S_PORT;
   logic [11:0] rd_addr = '0;
   logic [15:0] rd_data, hd_status, buf_rdata;
   logic [10:0] hd_len, buf_addr;
   logic        empty, hd_valid, hd_pop, keep_fcs;
   logic        frames_on = 1'b0;
   int          head = 0;
   int          checks = 0, errors = 0;

   always #10 clk = ~clk;

   function automatic logic [7:0] fb(int f, int k);
      return 8'(f * 37 + k * 5 + 1);
   endfunction
   function automatic int flen(int f);
      case (f)
         0: return 20;
         1: return 21;
         2: return 140;
         3: return 16;
         default: return 30;
      endcase
   endfunction
   function automatic logic [15:0] fstat(int f);
      return 16'hA500 + 16'(f);
   endfunction
   function automatic logic [7:0] sb(int f, int p);
      int rl;
      logic [15:0] s;
      rl = (f != 1) ? flen(f) : flen(f) - 4;
      s = fstat(f);
      case (p)
         0: return s[7:0];
         1: return s[15:8];
         2: return 8'(rl);
         3: return 8'(rl >> 8);
         default: return fb(f, p - 4);
      endcase
   endfunction
   function automatic logic [15:0] sw(int f, int p);
      return {sb(f, p + 1), sb(f, p)};
   endfunction

   assign hd_valid  = frames_on && (head < NF);
   assign hd_status = fstat(head);
   assign hd_len    = 11'(flen(head));
   assign keep_fcs  = (head != 1);
   assign buf_rdata = {fb(head, 2 * int'(buf_addr) + 1), fb(head, 2 * int'(buf_addr))};

   always @(posedge clk) if (hd_pop) head <= head + 1;

   rx_frame_read_port u_rx_frame_read_port (
      .clk(clk), .rst_n(rst_n), .keep_fcs(keep_fcs), .rd_en(rd_en),
      .rd_src(rd_src), .rd_addr(rd_addr), .rd_byte(rd_byte), .skip(skip),
      .rd_data(rd_data), .empty(empty), .hd_valid(hd_valid),
      .hd_status(hd_status), .hd_len(hd_len), .hd_pop(hd_pop),
      .buf_addr(buf_addr), .buf_rdata(buf_rdata)
   );

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(logic [1:0] src, logic [11:0] addr, logic byt, output logic [15:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_src = src; rd_addr = addr; rd_byte = byt;
      @(negedge clk);
      rd_en = 1'b0; rd_byte = 1'b0;
      d = rd_data;
   endtask

   task automatic do_skip();
      @(negedge clk);
      skip = 1'b1;
      @(negedge clk);
      skip = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset and nothing queued
      chk("R1 reset data", rd_data, 16'h0000);
      chk("R1 empty", 16'(empty), 16'h0001);
      rd(S_PORT, 12'h000, 1'b0, d); chk("R1 port read empty", d, 16'h0000);
      rd(S_EVT, 12'h000, 1'b0, d);  chk("R1 event read empty", d, 16'h0000);
      chk("R1 no pop", 16'(head), 16'h0000);
      frames_on = 1'b1;
      @(negedge clk);
      chk("R1 empty clears", 16'(empty), 16'h0000);

      // R2 R8: frame 0 through the data port, word reads
      for (int p = 0; p < 24; p += 2) begin
         if (p == 22) chk("R8 no early release", 16'(head), 16'h0000);
         rd(S_PORT, 12'h000, 1'b0, d);
         chk("R2 port word stream", d, sw(0, p));
      end
      chk("R8 release at stream end", 16'(head), 16'h0001);

      // R3 R4 R7 R8: frame 1, FCS dropped, window byte reads (stream 21)
      for (int p = 0; p < 21; p++) begin
         rd(S_WIN, 12'(12'h400 + p), 1'b1, d);
         chk("R4 R7 window byte stream", d, {8'h00, sb(1, p)});
      end
      chk("R3 R8 release after shortened stream", 16'(head), 16'h0002);

      // R5: frame 2, random word reads descending
      for (int off = 120; off >= 0; off -= 2) begin
         rd(S_WIN, 12'(12'h400 + off), 1'b0, d);
         chk("R5 random word", d, sw(2, off));
      end
      // pointer now 2
      rd(S_WIN, 12'h405, 1'b0, d); chk("R6 R3 odd offset gives length", d, 16'd140);
      rd(S_WIN, 12'h40A, 1'b1, d); chk("R6 R7 byte ignores address", d, {8'h00, fb(2, 0)});
      rd(S_PORT, 12'h000, 1'b0, d); chk("R7 odd pointer word", d, {fb(2, 1), fb(2, 0)});
      rd(S_WIN, 12'h482, 1'b0, d); chk("R6 beyond limit sequential", d, {fb(2, 3), fb(2, 2)});
      rd(S_WIN, 12'h3FE, 1'b0, d); chk("R11 below window zero", d, 16'h0000);
      rd(S_PORT, 12'h000, 1'b0, d); chk("R11 pointer kept", d, {fb(2, 5), fb(2, 4)});
      chk("R8 no release mid frame", 16'(head), 16'h0002);

      // R9: skip
      do_skip();
      chk("R9 skip pops", 16'(head), 16'h0003);
      rd(S_PORT, 12'h000, 1'b0, d); chk("R9 next frame status", d, fstat(3));

      // R10: event register
      rd(S_EVT, 12'h000, 1'b0, d); chk("R10 event returns status", d, fstat(3));
      chk("R10 event pops", 16'(head), 16'h0004);
      rd(S_PORT, 12'h000, 1'b0, d); chk("R10 R8 restart at status", d, fstat(4));
      rd(S_EVT, 12'h000, 1'b0, d); chk("R10 event last frame", d, fstat(4));
      chk("R10 queue drained", 16'(head), 16'h0005);
      @(negedge clk);
      chk("R1 empty after drain", 16'(empty), 16'h0001);
      rd(S_EVT, 12'h000, 1'b0, d); chk("R10 event after clear zero", d, 16'h0000);
      rd(S_PORT, 12'h000, 1'b0, d); chk("R1 port zero when empty", d, 16'h0000);
      rd(S_WIN, 12'h404, 1'b0, d); chk("R1 window zero when empty", d, 16'h0000);
      do_skip();
      chk("R1 R9 skip when empty no pop", 16'(head), 16'h0005);
      finish_run();
   end
endmodule